// File: doc/BRIEF.md
# Bit-Plane Rising-Edge Counter Bank

This block counts low-to-high transitions on a group of parallel input lines. Each line has its own 8-bit tally. The tallies are not held in one register per line. They are held as a stack of bit planes: plane k holds bit k of every line's tally, and the bit position inside a plane is the line number. On a sample strobe, the block compares the sampled input vector with the reference kept from the previous strobe. The resulting edge vector is then added to all tallies at once. It enters plane 0 as a shared carry vector and ripples upward plane by plane.

A host selects a line with an index. It gets that line's tally gathered from the planes, both combinationally and one cycle later from a register. A synchronous clear empties the tallies and the wrap flags, and takes a new reference from the current inputs. When a tally wraps, a per-line sticky flag records it. Input synchronisation is not part of the block. Inputs are taken as already synchronous to the clock.

Top module: `bitplane_pulse_counter`

## Requirements
- R1: While reset is low, and after it is released, every tally reads 0, both readout ports read 0 and every wrap flag is 0.
- R2: A strobe adds one to the tally of each line that shows a rising edge, in the clock edge that samples the strobe. Several lines may rise in the same strobe, and each advances independently.
- R3: An edge is a line that was 0 at the previous reference and is 1 in the strobed sample. A line that stays high, or that falls, does not advance. After each strobe the reference becomes the strobed sample.
- R4: Without a strobe, no tally changes and the reference is kept. Input changes between strobes are therefore seen only as the net difference at the next strobe.
- R5: The first clock cycle after reset release captures the inputs as the reference. A strobe in that cycle advances nothing.
- R6: A tally at 255 that gets an edge wraps to 0. The wrap flag for that line (bit i of the flag output is line i) is set and stays set until a clear, while counting goes on.
- R7: Clear empties every tally and every wrap flag, and loads the reference from the current inputs. A strobe in the same cycle as a clear advances nothing.
- R8: The combinational readout returns the tally of the line picked by the index, with tally bit k taken from plane k. During a strobe cycle it shows the value from before the increment.
- R9: The registered readout shows, one cycle later, what the combinational readout showed in the cycle before.
- R10: Strobes on consecutive cycles are each evaluated against the sample of the cycle just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clear | input | 1 | Synchronous clear of tallies and flags, reloads the reference |
| sample_en | input | 1 | Sample strobe, one cycle per sample |
| pins_i | input | 8 | Input lines, already synchronous to clk |
| rd_ch_i | input | 3 | Line index for readout |
| rd_cnt_o | output | 8 | Tally of the indexed line, combinational |
| rd_cnt_q_o | output | 8 | Registered readout, one cycle later |
| ovf_o | output | 8 | Sticky wrap flag per line |

## Verification
The assertions assume that `pins_i`, `sample_en` and `clear` are already synchronous and hold settled values at each clock edge. They also assume that these inputs carry known values from the first edge after reset. The bench meets this by changing every input only on the falling clock edge and by driving defined levels before reset is released. It keeps the inputs unchanged through the priming cycle, so that the reference the design captures matches the one the model assumes.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int unsigned LINES_DEF  = 8;
  localparam int unsigned TALLY_DEF  = 8;

  typedef enum logic [1:0] {
    REF_PRIME = 2'd0,
    REF_CLEAR = 2'd1,
    REF_SAMPLE = 2'd2,
    REF_HOLD = 2'd3
  } ref_act_e;
endpackage

// File: rtl/pcnt_edge_detect.sv
module pcnt_edge_detect
  import pcnt_pkg::*;
#(
  parameter int unsigned LINES = LINES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             clear_i,
  input  logic [LINES-1:0] pins_i,
  output logic [LINES-1:0] edge_o
);
  logic [LINES-1:0] ref_inv_q, ref_inv_d;
  logic             primed_q, primed_d;
  logic             ref_en;
  ref_act_e         act;

  always_comb begin
    if (!primed_q)      act = REF_PRIME;
    else if (clear_i)   act = REF_CLEAR;
    else if (strobe_i)  act = REF_SAMPLE;
    else                act = REF_HOLD;
  end

  always_comb begin
    ref_inv_d = ref_inv_q;
    primed_d  = primed_q;
    edge_o    = '0;
    ref_en    = 1'b0;
    unique case (act)
      REF_PRIME: begin
        ref_inv_d = ~pins_i;
        primed_d  = 1'b1;
        ref_en    = 1'b1;
      end
      REF_CLEAR: begin
        ref_inv_d = ~pins_i;
        ref_en    = 1'b1;
      end
      REF_SAMPLE: begin
        edge_o    = ref_inv_q & pins_i;
        ref_inv_d = ~pins_i;
        ref_en    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_inv_q <= '0;
      primed_q  <= 1'b0;
    end else if (ref_en) begin
      ref_inv_q <= ref_inv_d;
      primed_q  <= primed_d;
    end
  end

  AST_RISE_ONLY_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i || clear_i) |=> ((edge_o & $past(pins_i)) == '0)); // R3

  AST_CLEAR_BLOCKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && $past(primed_q)) |-> (edge_o == '0)); // R7
endmodule

// File: rtl/pcnt_plane_stack.sv
module pcnt_plane_stack
  import pcnt_pkg::*;
#(
  parameter int unsigned LINES = LINES_DEF,
  parameter int unsigned TALLY = TALLY_DEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_i,
  input  logic [LINES-1:0]            carry_in_i,
  output logic [TALLY-1:0][LINES-1:0] planes_o,
  output logic [LINES-1:0]            ovf_o
);
  localparam int unsigned TOP = TALLY - 1;

  logic [TALLY-1:0][LINES-1:0] planes_q, planes_d;
  logic [TALLY:0][LINES-1:0]   carry;
  logic [LINES-1:0]            ovf_q, ovf_d;
  logic                        upd_en;

  assign carry[0] = carry_in_i;

  for (genvar k = 0; k < TALLY; k++) begin : g_plane
    assign carry[k+1] = planes_q[k] & carry[k];
    always_comb begin
      if (clear_i) planes_d[k] = '0;
      else         planes_d[k] = planes_q[k] ^ carry[k];
    end
  end

  always_comb begin
    upd_en = clear_i | (|carry_in_i);
    if (clear_i) ovf_d = '0;
    else         ovf_d = ovf_q | carry[TALLY];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      planes_q <= '0;
      ovf_q    <= '0;
    end else if (upd_en) begin
      planes_q <= planes_d;
      ovf_q    <= ovf_d;
    end
  end

  assign planes_o = planes_q;
  assign ovf_o    = ovf_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && carry_in_i == '0) |=> $stable(planes_q)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R6

  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (((ovf_q & ~$past(ovf_q)) & ~($past(planes_q[TOP]) & ~planes_q[TOP])) == '0)); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (planes_q == '0 && ovf_q == '0)); // R7
endmodule

// File: rtl/pcnt_readout.sv
module pcnt_readout
  import pcnt_pkg::*;
#(
  parameter int unsigned LINES = LINES_DEF,
  parameter int unsigned TALLY = TALLY_DEF,
  localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_ch_i,
  input  logic [TALLY-1:0][LINES-1:0] planes_i,
  output logic [TALLY-1:0]            rd_comb_o,
  output logic [TALLY-1:0]            rd_q_o
);
  logic [LINES-1:0] sel_mask;
  logic [TALLY-1:0] rd_q;
  logic             rd_en;

  for (genvar c = 0; c < LINES; c++) begin : g_mask
    assign sel_mask[c] = (rd_ch_i == IDX_W'(c));
  end

  for (genvar k = 0; k < TALLY; k++) begin : g_gather
    assign rd_comb_o[k] = |(planes_i[k] & sel_mask);
  end

  assign rd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_comb_o;
  end

  assign rd_q_o = rd_q;

  AST_SEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_mask)); // R8
endmodule

// File: rtl/bitplane_pulse_counter.sv
module bitplane_pulse_counter
  import pcnt_pkg::*;
#(
  parameter int unsigned LINES = LINES_DEF,
  parameter int unsigned TALLY = TALLY_DEF,
  localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample_en,
  input  logic [LINES-1:0] pins_i,
  input  logic [IDX_W-1:0] rd_ch_i,
  output logic [TALLY-1:0] rd_cnt_o,
  output logic [TALLY-1:0] rd_cnt_q_o,
  output logic [LINES-1:0] ovf_o
);
  logic [LINES-1:0]            edges;
  logic [TALLY-1:0][LINES-1:0] planes;

  pcnt_edge_detect #(.LINES(LINES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (sample_en),
    .clear_i  (clear),
    .pins_i   (pins_i),
    .edge_o   (edges)
  );

  pcnt_plane_stack #(.LINES(LINES), .TALLY(TALLY)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .carry_in_i (edges),
    .planes_o   (planes),
    .ovf_o      (ovf_o)
  );

  pcnt_readout #(.LINES(LINES), .TALLY(TALLY)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ch_i   (rd_ch_i),
    .planes_i  (planes),
    .rd_comb_o (rd_cnt_o),
    .rd_q_o    (rd_cnt_q_o)
  );

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rd_cnt_o == '0 && ovf_o == '0)); // R7

  AST_QUIET_KEEPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !sample_en && $stable(rd_ch_i)) |=> $stable(rd_cnt_o)); // R4
endmodule

// File: tb/tb_bitplane_pulse_counter.sv
`timescale 1ns/100ps
module tb_bitplane_pulse_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       sample_en = 1'b0;
  logic [7:0] pins_i = 8'h00;
  logic [2:0] rd_ch_i = 3'd0;
  logic [7:0] rd_cnt_o, rd_cnt_q_o, ovf_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int         mdl_cnt [8];
  logic [7:0] mdl_ref;
  logic [7:0] mdl_ovf;

  // bit 8 = strobe, bits 7:0 = input byte
  localparam logic [8:0] VEC [16] = '{
    9'h1_00, 9'h1_01, 9'h1_03, 9'h1_02, 9'h0_FF, 9'h1_FF, 9'h1_00, 9'h0_AA,
    9'h0_00, 9'h1_55, 9'h1_AA, 9'h1_F0, 9'h1_0F, 9'h1_FF, 9'h1_80, 9'h1_81
  };

  bitplane_pulse_counter dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sample_en(sample_en),
    .pins_i(pins_i), .rd_ch_i(rd_ch_i), .rd_cnt_o(rd_cnt_o),
    .rd_cnt_q_o(rd_cnt_q_o), .ovf_o(ovf_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle, ends at the next falling edge
  task automatic step(input logic [7:0] p, input logic s);
    pins_i = p;
    sample_en = s;
    @(posedge clk);
    if (s) begin
      for (int c = 0; c < 8; c++) begin
        if (!mdl_ref[c] && p[c]) begin
          if (mdl_cnt[c] == 255) begin mdl_cnt[c] = 0; mdl_ovf[c] = 1'b1; end
          else mdl_cnt[c] = mdl_cnt[c] + 1;
        end
      end
      mdl_ref = p;
    end
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic do_clear(input logic [7:0] p, input logic s);
    pins_i = p;
    clear = 1'b1;
    sample_en = s;
    @(posedge clk);
    for (int c = 0; c < 8; c++) mdl_cnt[c] = 0;
    mdl_ovf = '0;
    mdl_ref = p;
    @(negedge clk);
    clear = 1'b0;
    sample_en = 1'b0;
  endtask

  task automatic check_all(input string rq);
    for (int c = 0; c < 8; c++) begin
      rd_ch_i = 3'(c);
      #0.1;
      chk(rq, rd_cnt_o, 8'(mdl_cnt[c]), $sformatf("line %0d tally", c));
    end
    chk(rq, ovf_o, mdl_ovf, "wrap flags");
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] old;
    for (int c = 0; c < 8; c++) mdl_cnt[c] = 0;
    mdl_ovf = '0;
    pins_i = 8'h00;
    #9;
    // R1: reset state while reset is asserted
    chk("R1", rd_cnt_o, 8'h00, "tally in reset");
    chk("R1", rd_cnt_q_o, 8'h00, "registered read in reset");
    chk("R1", ovf_o, 8'h00, "flags in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R5: priming cycle with inputs high and a strobe: nothing counts
    pins_i = 8'hFF;
    sample_en = 1'b1;
    @(posedge clk);
    mdl_ref = 8'hFF;
    @(negedge clk);
    sample_en = 1'b0;
    check_all("R5");
    step(8'hFF, 1'b1);
    check_all("R5");

    // R2 R3 R4 R10: table walk, strobes on consecutive cycles
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][7:0], VEC[i][8]);
      check_all(VEC[i][8] ? "R3" : "R4");
    end

    // R10: back-to-back alternating strobes
    for (int i = 0; i < 6; i++) step((i % 2 == 0) ? 8'h00 : 8'hFF, 1'b1);
    check_all("R10");

    // R8 R9: read during strobe shows old value, registered copy a cycle later
    step(8'h00, 1'b1);
    rd_ch_i = 3'd2;
    old = 8'(mdl_cnt[2]);
    pins_i = 8'h04;
    sample_en = 1'b1;
    #0.1;
    chk("R8", rd_cnt_o, old, "read during strobe");
    @(posedge clk);
    mdl_cnt[2] = mdl_cnt[2] + 1;
    mdl_ref = 8'h04;
    @(negedge clk);
    sample_en = 1'b0;
    chk("R9", rd_cnt_q_o, old, "registered read");
    chk("R2", rd_cnt_o, 8'(mdl_cnt[2]), "read after strobe");

    // R7: clear with a simultaneous strobe and inputs high
    do_clear(8'hFF, 1'b1);
    check_all("R7");
    step(8'hFF, 1'b1);
    check_all("R7");
    step(8'h00, 1'b1);
    step(8'hFF, 1'b1);
    check_all("R7");

    // R6: wrap of line 3
    do_clear(8'h00, 1'b0);
    for (int i = 0; i < 255; i++) begin
      step(8'h08, 1'b1);
      step(8'h00, 1'b1);
    end
    check_all("R6");
    step(8'h08, 1'b1);
    check_all("R6");
    chk("R6", ovf_o, 8'h08, "flag for line 3 only");
    step(8'h00, 1'b1);
    step(8'h08, 1'b1);
    check_all("R6");

    // R2 R3: random bytes with random strobes
    for (int i = 0; i < 300; i++) begin
      step(8'($urandom), 1'($urandom % 4 != 0));
      if (i % 10 == 9) check_all("R2");
    end
    check_all("R3");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule